// File: doc/BRIEF.md
# Cascaded Table Full Detector

This block keeps an occupied flag for every entry of one search device's table. It works out whether the device has any empty entry left, and it builds a fullness indication that grows along a chain of up to a group of devices. Two kinds of write change a flag. A learn places a new entry in the lowest-numbered empty slot and marks it occupied. A programmed write stores the occupancy bit (bit 0 of the written word) at an explicit address. The stored flags feed a running count of occupied entries. The device is full when that count equals the table depth. The full status is recomputed only on a write cycle.

Each device drives a two-bit full pair to the devices below it, with both bits carrying its own full status. It receives the pairs of the devices above it through a packed upstream bus. Upstream slot j belongs to the device at group position j. A device at position P looks only at slots 0 to P-1 and treats every other slot as asserted. The first device in the chain therefore sees no missing upstream state. The cumulative output is high only when this device and every device above it are full. On the board, only the last device of the group returns it to the host.

When learn is never used, software keeps bit 0 of every entry at 1, so entries never appear empty.

Top module: `cfd_full_detect`

## Requirements
- R1: After reset every entry is empty: own_full_o is 2'b00, chain_full_o is 0, free_vld_o is 1 and free_idx_o is 0.
- R2: A learn (wr_en_i=1, wr_learn_i=1) while an empty entry exists marks the entry at free_idx_o occupied. From the next cycle free_idx_o shows the next empty entry.
- R3: A programmed write (wr_en_i=1, wr_learn_i=0) sets the flag of entry wr_addr_i to wr_occ_i: 1 means occupied and 0 means empty.
- R4: In the cycle after a write that leaves no empty entry, own_full_o becomes 2'b11 and free_vld_o becomes 0. In the cycle after a write that empties an entry, own_full_o becomes 2'b00.
- R5: A write that stores the same occupancy value an entry already holds leaves the occupied count unchanged.
- R6: A learn while the table is full has no effect: own_full_o stays 2'b11 and free_vld_o stays 0.
- R7: chain_full_o is 1 only when own_full_o is 2'b11 and both bits of every upstream pair in slots 0 to DEV_POS-1 are 1. Pair j occupies bits 2j+1:2j of up_full_i.
- R8: Upstream slots at index DEV_POS and above are ignored. A device with DEV_POS=0 drives chain_full_o equal to its own full status.
- R9: free_idx_o is the lowest-numbered empty entry, and free_vld_o is 1 exactly when one exists.
- R10: own_full_o changes only in the cycle after a cycle with wr_en_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write operation valid this cycle |
| wr_learn_i | input | 1 | 1 = learn into the lowest empty entry, 0 = programmed write |
| wr_addr_i | input | IDXW | Entry address of a programmed write |
| wr_occ_i | input | 1 | Bit 0 of the programmed write data (occupancy) |
| up_full_i | input | 2*(GRP_MAX-1) | Full pairs from upstream devices, pair j at bits 2j+1:2j |
| own_full_o | output | 2 | This device's full status, driven on both bits |
| chain_full_o | output | 1 | Cumulative full status of this device and all devices above |
| free_idx_o | output | IDXW | Lowest empty entry index |
| free_vld_o | output | 1 | An empty entry exists |

## Verification
The bench builds the main instance with DEPTH=8, GRP_MAX=8 and DEV_POS=3. The shallow table can be filled, drained and refilled in a few dozen writes. Placing the device mid-chain lets one upstream bus show pairs that are counted and pairs that are ignored. A second instance with DEPTH=4 and DEV_POS=0 stands at the head of the chain. With its upstream bus held at zero, its cumulative output must still follow its own fullness.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  // Kind of write carried by wr_learn_i
  typedef enum logic {
    OP_PIO   = 1'b0,
    OP_LEARN = 1'b1
  } cfd_op_e;

  localparam int unsigned FULL_PAIR_W = 2;

endpackage

// File: rtl/cfd_rst_sync.sv
module cfd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/cfd_occ_map.sv
module cfd_occ_map #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDXW  = $clog2(DEPTH),
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic             val_i,
  output logic [DEPTH-1:0] occ_o,
  output logic [CNTW-1:0]  cnt_o,
  output logic [CNTW-1:0]  cnt_nxt_o
);

  logic [DEPTH-1:0] occ_q;
  logic [CNTW-1:0]  cnt_q;
  logic [CNTW-1:0]  cnt_d;
  logic             old_val;
  logic             inc;
  logic             dec;

  // Per-entry occupancy flags, one enabled register each
  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    logic hit;
    logic flag_d;
    assign hit = we_i && (idx_i == IDXW'(g));

    always_comb begin
      flag_d = occ_q[g];
      if (hit) flag_d = val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  occ_q[g] <= 1'b0;
      else if (hit) occ_q[g] <= flag_d;
    end
  end

  // Count moves only when the stored flag actually flips
  always_comb begin
    old_val = occ_q[idx_i];
    inc     = we_i &&  val_i && !old_val;
    dec     = we_i && !val_i &&  old_val;
    cnt_d   = cnt_q;
    if (inc)      cnt_d = cnt_q + CNTW'(1);
    else if (dec) cnt_d = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (we_i) cnt_q <= cnt_d;
  end

  assign occ_o     = occ_q;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

endmodule

// File: rtl/cfd_free_find.sv
module cfd_free_find #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDXW  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] occ_i,
  output logic [IDXW-1:0]  idx_o,
  output logic             vld_o
);

  // Lowest empty entry wins: scan from the top so lower indices overwrite
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ_i[i]) idx_o = IDXW'(i);
    end
    vld_o = ~&occ_i;
  end

endmodule

// File: rtl/cfd_chain.sv
module cfd_chain #(
  parameter int unsigned GRP_MAX = 8,
  parameter int unsigned DEV_POS = 0,
  parameter int unsigned UPW     = 2 * (GRP_MAX - 1)
) (
  input  logic [UPW-1:0] up_full_i,
  input  logic           own_full_i,
  output logic           chain_full_o
);

  localparam int unsigned NUP = GRP_MAX - 1;

  logic [NUP-1:0] slot_ok;

  for (genvar j = 0; j < NUP; j++) begin : g_slot
    if (j < DEV_POS) begin : g_used
      // A pair counts as full only with both of its bits high
      assign slot_ok[j] = &up_full_i[2*j +: cfd_pkg::FULL_PAIR_W];
    end else begin : g_absent
      assign slot_ok[j] = 1'b1;
    end
  end

  assign chain_full_o = own_full_i && (&slot_ok);

endmodule

// File: rtl/cfd_full_detect.sv
module cfd_full_detect #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned GRP_MAX = 8,
  parameter int unsigned DEV_POS = 0,
  localparam int unsigned IDXW   = $clog2(DEPTH),
  localparam int unsigned UPW    = 2 * (GRP_MAX - 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_learn_i,
  input  logic [IDXW-1:0] wr_addr_i,
  input  logic            wr_occ_i,
  input  logic [UPW-1:0]  up_full_i,
  output logic [1:0]      own_full_o,
  output logic            chain_full_o,
  output logic [IDXW-1:0] free_idx_o,
  output logic            free_vld_o
);

  import cfd_pkg::*;

  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic             rst_n;
  logic [DEPTH-1:0] occ;
  logic [CNTW-1:0]  cnt;
  logic [CNTW-1:0]  cnt_nxt;
  logic [IDXW-1:0]  free_idx;
  logic             free_vld;
  cfd_op_e          op;
  logic             map_we;
  logic [IDXW-1:0]  map_idx;
  logic             map_val;
  logic             full_q;
  logic             full_d;

  cfd_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  // Learn targets the lowest empty entry; a learn into a full table is dropped
  always_comb begin
    op      = cfd_op_e'(wr_learn_i);
    map_we  = 1'b0;
    map_idx = wr_addr_i;
    map_val = wr_occ_i;
    if (wr_en_i) begin
      if (op == OP_LEARN) begin
        map_we  = free_vld;
        map_idx = free_idx;
        map_val = 1'b1;
      end else begin
        map_we  = 1'b1;
      end
    end
  end

  cfd_occ_map #(
    .DEPTH (DEPTH),
    .IDXW  (IDXW),
    .CNTW  (CNTW)
  ) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (map_we),
    .idx_i     (map_idx),
    .val_i     (map_val),
    .occ_o     (occ),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  cfd_free_find #(
    .DEPTH (DEPTH),
    .IDXW  (IDXW)
  ) u_find (
    .occ_i (occ),
    .idx_o (free_idx),
    .vld_o (free_vld)
  );

  // Full status is re-evaluated on every write cycle, held otherwise
  always_comb begin
    full_d = full_q;
    if (wr_en_i) full_d = (cnt_nxt == CNTW'(DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (wr_en_i) full_q <= full_d;
  end

  cfd_chain #(
    .GRP_MAX (GRP_MAX),
    .DEV_POS (DEV_POS),
    .UPW     (UPW)
  ) u_chain (
    .up_full_i    (up_full_i),
    .own_full_i   (full_q),
    .chain_full_o (chain_full_o)
  );

  assign own_full_o = {full_q, full_q};
  assign free_idx_o = free_idx;
  assign free_vld_o = free_vld;

endmodule

// File: rtl/cfd_full_detect_chk.sv
module cfd_full_detect_chk #(
  parameter int unsigned IDXW = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            wr_learn_i,
  input logic            wr_occ_i,
  input logic [1:0]      own_full_o,
  input logic            chain_full_o,
  input logic [IDXW-1:0] free_idx_o,
  input logic            free_vld_o
);

  // R10: full status moves only after a write cycle
  a_r10_full_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(own_full_o));

  // R4: a full device has no empty entry to offer
  a_r4_full_no_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_full_o[0] |-> !free_vld_o);

  // R7: cumulative full requires this device to be full
  a_r7_chain_needs_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_full_o |-> own_full_o[0]);

  // R6: a learn into a full table leaves it full
  a_r6_learn_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_learn_i && own_full_o[0]) |=> own_full_o[0]);

  // R3: a programmed clear always leaves an empty entry
  a_r3_clear_unfull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_learn_i && !wr_occ_i) |=> (!own_full_o[0] && free_vld_o));

endmodule

bind cfd_full_detect cfd_full_detect_chk #(.IDXW(IDXW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_learn_i   (wr_learn_i),
  .wr_occ_i     (wr_occ_i),
  .own_full_o   (own_full_o),
  .chain_full_o (chain_full_o),
  .free_idx_o   (free_idx_o),
  .free_vld_o   (free_vld_o)
);

// File: tb/cfd_full_detect_tb_top.sv
module cfd_full_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en, wr_en_f, wr_learn, wr_occ;
  logic [2:0]  wr_addr;
  logic [13:0] up_full, up_full_f;
  logic [1:0]  own_full, own_full_f;
  logic        chain_full, chain_full_f;
  logic [2:0]  free_idx;
  logic [1:0]  free_idx_f;
  logic        free_vld, free_vld_f;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cfd_full_detect #(.DEPTH(8), .GRP_MAX(8), .DEV_POS(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_learn_i(wr_learn),
    .wr_addr_i(wr_addr), .wr_occ_i(wr_occ), .up_full_i(up_full),
    .own_full_o(own_full), .chain_full_o(chain_full),
    .free_idx_o(free_idx), .free_vld_o(free_vld)
  );

  cfd_full_detect #(.DEPTH(4), .GRP_MAX(8), .DEV_POS(0)) dut_first_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_f), .wr_learn_i(wr_learn),
    .wr_addr_i(wr_addr[1:0]), .wr_occ_i(wr_occ), .up_full_i(up_full_f),
    .own_full_o(own_full_f), .chain_full_o(chain_full_f),
    .free_idx_o(free_idx_f), .free_vld_o(free_vld_f)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One operation: drive at a falling edge, sample at the next falling edge
  task automatic op(bit main_en, bit first_en, bit learn, logic [2:0] addr, bit occ);
    @(negedge clk);
    wr_en = main_en; wr_en_f = first_en; wr_learn = learn; wr_addr = addr; wr_occ = occ;
    @(negedge clk);
    wr_en = 1'b0; wr_en_f = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 own_full", 32'(own_full), 32'h0);
    chk("R1 chain_full", 32'(chain_full), 32'h0);
    chk("R1 free_vld", 32'(free_vld), 32'h1);
    chk("R1 free_idx", 32'(free_idx), 32'h0);
    chk("R1 first own_full", 32'(own_full_f), 32'h0);
  endtask

  task automatic t_learn_fill();
    for (int i = 0; i < 8; i++) begin
      op(1'b1, 1'b0, 1'b1, 3'd0, 1'b0);
      if (i < 7) begin
        chk("R2 R9 next free", 32'(free_idx), 32'(i + 1));
        chk("R4 not yet full", 32'(own_full), 32'h0);
      end else begin
        chk("R4 full pair", 32'(own_full), 32'h3);
        chk("R4 R9 no free", 32'(free_vld), 32'h0);
        chk("R7 upstream low", 32'(chain_full), 32'h0);
      end
    end
  endtask

  task automatic t_full_learn();
    op(1'b1, 1'b0, 1'b1, 3'd0, 1'b0);
    chk("R6 learn full own", 32'(own_full), 32'h3);
    chk("R6 learn full vld", 32'(free_vld), 32'h0);
    op(1'b1, 1'b0, 1'b0, 3'd5, 1'b0);
    chk("R3 R4 clear own", 32'(own_full), 32'h0);
    chk("R3 R9 free idx", 32'(free_idx), 32'h5);
    op(1'b1, 1'b0, 1'b1, 3'd0, 1'b0);
    chk("R2 refill own", 32'(own_full), 32'h3);
  endtask

  task automatic t_redundant();
    op(1'b1, 1'b0, 1'b0, 3'd2, 1'b1);
    chk("R5 rewrite set", 32'(own_full), 32'h3);
    op(1'b1, 1'b0, 1'b0, 3'd2, 1'b0);
    chk("R3 clear 2", 32'(free_idx), 32'h2);
    op(1'b1, 1'b0, 1'b0, 3'd2, 1'b0);
    chk("R5 rewrite clear", 32'(own_full), 32'h0);
    op(1'b1, 1'b0, 1'b0, 3'd2, 1'b1);
    chk("R5 count intact", 32'(own_full), 32'h3);
  endtask

  task automatic t_chain();
    @(negedge clk); up_full = 14'h003F;
    #1 chk("R7 R8 all used full", 32'(chain_full), 32'h1);
    @(negedge clk); up_full = 14'h0037;
    #1 chk("R7 half pair", 32'(chain_full), 32'h0);
    @(negedge clk); up_full = 14'h000F;
    #1 chk("R7 slot2 low", 32'(chain_full), 32'h0);
    @(negedge clk); up_full = 14'h3FC0 | 14'h003F;
    #1 chk("R8 extra slots", 32'(chain_full), 32'h1);
    op(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R7 own empty", 32'(chain_full), 32'h0);
    op(1'b1, 1'b0, 1'b0, 3'd0, 1'b1);
    chk("R7 own full again", 32'(chain_full), 32'h1);
  endtask

  task automatic t_idle();
    @(negedge clk); up_full = 14'h0;
    repeat (3) @(negedge clk);
    chk("R10 idle hold", 32'(own_full), 32'h3);
  endtask

  task automatic t_first();
    for (int i = 0; i < 4; i++) begin
      op(1'b0, 1'b1, 1'b1, 3'd0, 1'b0);
      if (i < 3) chk("R8 first not full", 32'(chain_full_f), 32'h0);
    end
    chk("R8 first own", 32'(own_full_f), 32'h3);
    chk("R8 first chain", 32'(chain_full_f), 32'h1);
  endtask

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; wr_en_f = 1'b0; wr_learn = 1'b0;
    wr_occ = 1'b0; wr_addr = '0; up_full = '0; up_full_f = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_learn_fill();
    t_full_learn();
    t_redundant();
    t_chain();
    t_idle();
    t_first();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule